// File: doc/BRIEF.md
# Iterative Integer Quotient Unit

This block computes the 32-bit quotient of two register operands for a processor pipeline. A one-cycle start strobe hands it a dividend, a divisor, a signed/unsigned select and the index of the destination register. The unit first spends one cycle preparing operand magnitudes. It then spends 32 cycles on restoring shift-subtract steps, producing one quotient bit in each. When the last step finishes, it raises a one-cycle done pulse that carries the final quotient and a register write request.

There is no trapping path. Two cases would otherwise need one: a zero divisor, and the signed quotient of the most negative value by minus one. In both cases the unit uses a divisor of one, so the quotient it returns is the dividend unchanged. Signed quotients truncate toward zero. They are formed by dividing the magnitudes and then negating the result when the operand signs differ.

Top module: `iter_div32`

## Requirements
- R1: In unsigned mode (`sgn_i`=0) both operands are zero-extended, and for a nonzero divisor the quotient is floor(dividend / divisor).
- R2: In signed mode (`sgn_i`=1) both operands are two's-complement values, and the quotient truncates toward zero (for example -7 / 2 = -3 and -7 / -2 = 3).
- R3: A zero divisor produces a quotient equal to the dividend, in both modes.
- R4: In signed mode, 0x80000000 divided by 0xFFFFFFFF produces 0x80000000. In unsigned mode the same operands produce 0.
- R5: An accepted start raises `busy_o` in the next cycle. `busy_o` stays high for exactly 33 cycles. `done_o` is then high for exactly one cycle, and `busy_o` and `done_o` are never high together. A start is accepted while idle and also in the done cycle.
- R6: A start that arrives while `busy_o` is high is ignored. The operation in flight completes with its own operands and destination.
- R7: `wr_en_o` is high only in the done cycle, and only when the destination index captured at start is nonzero. `wr_idx_o` carries that captured index.
- R8: An active-low reset forces `busy_o`, `done_o` and `wr_en_o` low at once and abandons any operation in flight, so no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| sgn_i | input | 1 | 1 = signed quotient, 0 = unsigned |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| dest_i | input | 5 | Destination register index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | 32 | Quotient, valid while `done_o` is high |
| wr_en_o | output | 1 | Register write request |
| wr_idx_o | output | 5 | Destination index for the write |

## Verification
Several properties are checked on every cycle:
- busy and done are mutually exclusive, and done is a single-cycle pulse;
- the busy window always lasts 33 cycles;
- captured operands stay frozen while busy;
- a write request appears only with done and a nonzero index;
- at every completion, the zero-divisor and most-negative-by-minus-one substitutions hold.

Some behaviours only the bench scenarios can show: arithmetic correctness of ordinary quotients, truncation and sign handling, acceptance of a start in the done cycle, and the abandoning of an operation by reset. For those, the bench compares outputs cycle by cycle against a behavioural model.

// File: rtl/iter_div32_pkg.sv
package iter_div32_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ITER  = 2'd2,
        PH_FIN   = 2'd3
    } div_phase_e;

endpackage

// File: rtl/iter_div32_prep.sv
// Operand preparation: corner-case divisor substitution and magnitude forming.
module iter_div32_prep #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] num_i,
    input  logic [DATA_W-1:0] den_i,
    input  logic              sgn_i,
    output logic [DATA_W-1:0] num_mag_o,
    output logic [DATA_W-1:0] den_mag_o,
    output logic              neg_o
);
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ALL_ONES = '1;
    localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

    logic              den_zero;
    logic              ovf_case;
    logic [DATA_W-1:0] den_eff;
    logic              num_neg;
    logic              den_neg;

    always_comb begin
        den_zero  = (den_i == '0);
        ovf_case  = sgn_i && (num_i == MOST_NEG) && (den_i == ALL_ONES);
        den_eff   = (den_zero || ovf_case) ? ONE : den_i;
        num_neg   = sgn_i && num_i[DATA_W-1];
        den_neg   = sgn_i && den_eff[DATA_W-1];
        num_mag_o = num_neg ? (~num_i + ONE) : num_i;
        den_mag_o = den_neg ? (~den_eff + ONE) : den_eff;
        neg_o     = num_neg ^ den_neg;
    end
endmodule

// File: rtl/iter_div32_step.sv
// One restoring shift-subtract step producing a single quotient bit.
module iter_div32_step #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] rem_i,
    input  logic [DATA_W-1:0] quo_i,
    input  logic [DATA_W-1:0] den_i,
    output logic [DATA_W-1:0] rem_o,
    output logic [DATA_W-1:0] quo_o
);
    logic [DATA_W:0] shifted;
    logic [DATA_W:0] trial;
    logic            fits;

    always_comb begin
        shifted = {rem_i, quo_i[DATA_W-1]};
        trial   = shifted - {1'b0, den_i};
        fits    = ~trial[DATA_W];
        rem_o   = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
        quo_o   = {quo_i[DATA_W-2:0], fits};
    end
endmodule

// File: rtl/iter_div32_fix.sv
// Applies the result sign to the unsigned quotient magnitude.
module iter_div32_fix #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] mag_i,
    input  logic              neg_i,
    output logic [DATA_W-1:0] res_o
);
    always_comb begin
        res_o = neg_i ? (~mag_i + DATA_W'(1)) : mag_i;
    end
endmodule

// File: rtl/iter_div32.sv
module iter_div32
    import iter_div32_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sgn_i,
    input  logic [DATA_W-1:0] dividend_i,
    input  logic [DATA_W-1:0] divisor_i,
    input  logic [IDX_W-1:0]  dest_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] quotient_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o
);
    localparam int                CNT_W    = $clog2(DATA_W);
    localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(DATA_W - 1);
    localparam int                RUN_W    = $clog2(DATA_W + 2) + 1;
    localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        div_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] op_a;
        logic [DATA_W-1:0] op_b;
        logic              sgn;
        logic [IDX_W-1:0]  dest;
        logic [DATA_W-1:0] rem;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] den;
        logic              neg;
        logic [DATA_W-1:0] result;
    } div_state_t;

    div_state_t st_d, st_q;

    logic [DATA_W-1:0] num_mag, den_mag;
    logic              neg_res;
    logic [DATA_W-1:0] step_rem, step_quo;
    logic [DATA_W-1:0] fixed_res;

    iter_div32_prep #(.DATA_W(DATA_W)) prep_i (
        .num_i     (st_q.op_a),
        .den_i     (st_q.op_b),
        .sgn_i     (st_q.sgn),
        .num_mag_o (num_mag),
        .den_mag_o (den_mag),
        .neg_o     (neg_res)
    );

    iter_div32_step #(.DATA_W(DATA_W)) step_i (
        .rem_i (st_q.rem),
        .quo_i (st_q.quo),
        .den_i (st_q.den),
        .rem_o (step_rem),
        .quo_o (step_quo)
    );

    iter_div32_fix #(.DATA_W(DATA_W)) fix_i (
        .mag_i (step_quo),
        .neg_i (st_q.neg),
        .res_o (fixed_res)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE, PH_FIN: begin
                st_d.phase = PH_IDLE;
                if (start_i) begin
                    st_d.phase = PH_SETUP;
                    st_d.op_a  = dividend_i;
                    st_d.op_b  = divisor_i;
                    st_d.sgn   = sgn_i;
                    st_d.dest  = dest_i;
                end
            end
            PH_SETUP: begin
                st_d.phase = PH_ITER;
                st_d.cnt   = '0;
                st_d.rem   = '0;
                st_d.quo   = num_mag;
                st_d.den   = den_mag;
                st_d.neg   = neg_res;
            end
            PH_ITER: begin
                st_d.rem = step_rem;
                st_d.quo = step_quo;
                st_d.cnt = st_q.cnt + CNT_W'(1);
                if (st_q.cnt == LAST_CNT) begin
                    st_d.phase  = PH_FIN;
                    st_d.result = fixed_res;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy_o     = (st_q.phase == PH_SETUP) || (st_q.phase == PH_ITER);
        done_o     = (st_q.phase == PH_FIN);
        quotient_o = st_q.result;
        wr_idx_o   = st_q.dest;
        wr_en_o    = done_o && (st_q.dest != '0);
    end

    // Length of the current busy window, for the timing property.
    logic [RUN_W-1:0] busy_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run_q <= '0;
        end else if (busy_o) begin
            busy_run_q <= busy_run_q + RUN_W'(1);
        end else begin
            busy_run_q <= '0;
        end
    end

    assert_no_busy_done_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_done_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_window_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (busy_run_q == RUN_W'(DATA_W + 1)) && done_o);

    assert_ops_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(st_q.op_a) && $stable(st_q.op_b) && $stable(st_q.dest));

    assert_write_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o && (wr_idx_o != '0));

    assert_zero_div_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (st_q.op_b == '0)) |-> (quotient_o == st_q.op_a));

    assert_most_neg_by_m1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && st_q.sgn && (st_q.op_a == MOST_NEG) && (st_q.op_b == '1))
        |-> (quotient_o == MOST_NEG));
endmodule

// File: tb/iter_div32_tb_top.sv
module iter_div32_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic        sgn;
    logic [31:0] a_in, b_in;
    logic [4:0]  d_in;
    logic        busy_o, done_o, wr_en_o;
    logic [31:0] quotient_o;
    logic [4:0]  wr_idx_o;

    always #5 clk = ~clk;

    iter_div32 dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .sgn_i      (sgn),
        .dividend_i (a_in),
        .divisor_i  (b_in),
        .dest_i     (d_in),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .quotient_o (quotient_o),
        .wr_en_o    (wr_en_o),
        .wr_idx_o   (wr_idx_o)
    );

    int    total = 0;
    int    bad   = 0;
    bit    running = 1'b0;
    string cur_tag = "R5";

    function automatic logic [31:0] ref_div(logic [31:0] x, logic [31:0] y, logic s);
        longint sx, sy;
        if (y == 32'd0) return x;
        if (s) begin
            sx = longint'($signed(x));
            sy = longint'($signed(y));
            if (sx == -64'sd2147483648 && sy == -64'sd1) return x;
            return 32'(sx / sy);
        end
        return x / y;
    endfunction

    // Behavioural reference: remaining busy cycles and a done flag.
    int          m_left;
    logic        m_done;
    logic [31:0] m_q, ca, cb;
    logic        cs;
    logic [4:0]  cd, m_dest;
    string       ctag, m_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_left <= 0;
            m_done <= 1'b0;
        end else begin
            m_done <= 1'b0;
            if (m_left > 0) begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_done <= 1'b1;
                    m_q    <= ref_div(ca, cb, cs);
                    m_dest <= cd;
                    m_tag  <= ctag;
                end
            end else if (start) begin
                m_left <= 33;
                ca <= a_in; cb <= b_in; cs <= sgn; cd <= d_in; ctag <= cur_tag;
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk(busy_o === (m_left > 0), rst_n ? "R5 busy" : "R8 busy",
                32'(busy_o), 32'(m_left > 0));
            chk(done_o === m_done, rst_n ? "R5 done" : "R8 done",
                32'(done_o), 32'(m_done));
            chk(wr_en_o === (m_done && m_dest != 5'd0), "R7 wr_en",
                32'(wr_en_o), 32'(m_done && m_dest != 5'd0));
            if (m_done) begin
                chk(quotient_o === m_q, m_tag, quotient_o, m_q);
                chk(wr_idx_o === m_dest, "R7 wr_idx", 32'(wr_idx_o), 32'(m_dest));
            end
        end
    end

    task automatic kick(logic [31:0] x, logic [31:0] y, logic s, logic [4:0] d, string tag);
        @(negedge clk);
        a_in = x; b_in = y; sgn = s; d_in = d; cur_tag = tag; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_op(logic [31:0] x, logic [31:0] y, logic s, logic [4:0] d, string tag);
        kick(x, y, s, d, tag);
        repeat (35) @(negedge clk);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL R5 watchdog expired act=%h exp=%h", 32'd1, 32'd0);
        summary();
    end

    initial begin
        logic [31:0] lf;
        rst_n = 1'b0; start = 1'b0; sgn = 1'b0; a_in = '0; b_in = '0; d_in = '0;
        running = 1'b1;
        repeat (3) @(negedge clk);       // R8 reset state checked each cycle
        rst_n = 1'b1;

        run_op(32'd100, 32'd7, 1'b0, 5'd3, "R1 100/7");
        run_op(32'hFFFF_FFFF, 32'd1, 1'b0, 5'd4, "R1 max/1");
        run_op(32'hFFFF_FFFF, 32'h0001_0000, 1'b0, 5'd5, "R1 max/65536");
        run_op(32'd5, 32'd9, 1'b0, 5'd6, "R1 small/large");
        run_op(-32'sd7, 32'd2, 1'b1, 5'd7, "R2 -7/2");
        run_op(32'd7, -32'sd2, 1'b1, 5'd8, "R2 7/-2");
        run_op(-32'sd7, -32'sd2, 1'b1, 5'd9, "R2 -7/-2");
        run_op(32'h8000_0000, 32'd2, 1'b1, 5'd10, "R2 min/2");
        run_op(32'h8000_0000, 32'd2, 1'b0, 5'd10, "R1 0x80000000/2 unsigned");
        run_op(32'h1234_5678, 32'd0, 1'b0, 5'd11, "R3 unsigned div0");
        run_op(-32'sd12345, 32'd0, 1'b1, 5'd12, "R3 signed div0");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, 5'd13, "R4 signed min/-1");
        run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b0, 5'd14, "R4 unsigned same operands");
        run_op(32'd50, 32'd5, 1'b0, 5'd0, "R7 dest zero");

        // R6: a second start while busy must be ignored
        kick(32'd1000, 32'd10, 1'b0, 5'd15, "R6 first op");
        repeat (10) @(negedge clk);
        a_in = 32'd9; b_in = 32'd3; d_in = 5'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);

        // R5: start accepted in the done cycle
        kick(32'd81, 32'd9, 1'b0, 5'd16, "R5 first of pair");
        repeat (33) @(negedge clk);
        a_in = -32'sd81; b_in = 32'd9; sgn = 1'b1; d_in = 5'd17; cur_tag = "R5 second of pair";
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (36) @(negedge clk);

        // R8: reset in mid-operation abandons the result
        kick(32'd77, 32'd7, 1'b0, 5'd18, "R8 aborted op");
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);

        lf = 32'hACE1_2468;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] x, y;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            x = lf;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            y = lf >> (i % 29);
            run_op(x, y, i[0], 5'(i + 1), i[0] ? "R2 pattern" : "R1 pattern");
        end

        running = 1'b0;
        summary();
    end
endmodule